// File: doc/BRIEF.md
# Single-Operand Bit Manipulation Unit

This block applies one bit-level function to a byte and an incoming carry. It produces a result byte and an outgoing carry. The carry acts as a ninth cell next to the byte, so logic results, swaps, copies, rotates and shifts can move bits into or out of it. Two fields of an 8-bit function code pick bit positions N and M. A 2-bit mode input selects one of four function families: bit pairs, carry-linked operations, miscellaneous functions (cellular step, counts and conversions) and pass-through.

The function logic is combinational. Its result is captured in a one-entry output register that is wrapped in a valid/ready stream. An input transfer takes place on a rising clock edge where `in_valid` and `in_ready` are both high. An output transfer takes place on an edge where `out_valid` and `out_ready` are both high. `in_ready` is high when the register is empty or is being drained in the same cycle. This gives full throughput when the consumer always accepts, and it passes back-pressure through without any extra storage.

Top module: `bitop_unit`

## Requirements
- R1: An accepted operation appears on `out_data`/`out_carry` with `out_valid` high in the cycle after the accepting edge. `in_ready` is low while `out_valid` is high and `out_ready` is low. While stalled, the output stays valid and its value does not change.
- R2: After reset, `out_valid` is 0 and `in_ready` is 1.
- R3: Mode 0, with op[7:6] equal to 0, 1 or 2, forms AND, OR or XOR of operand bits N (op[5:3]) and M (op[2:0]). The value is written to result bit M and to the carry out. All other bits are unchanged.
- R4: Mode 0, op[7:6]=3, exchanges bits N and M. Carry passes through.
- R5: Mode 1, with op[7:6] equal to 0, 1 or 2, forms AND, OR or XOR of bit N and carry in. The value is written to bit M and to the carry out.
- R6: Mode 1, op[7:6]=3 with M=0, swaps bit N and the carry. With M=1 it copies carry into bit N and leaves the carry unchanged. Mode 2, op[7:6]=3, copies bit N to the carry and leaves the byte unchanged.
- R7: Mode 1, op[7:6]=3, rotates the 9-bit ring {carry, byte} until bit N sits in the carry. With M=2 the ring rotates left (8-N steps: bit 7 moves into the carry and the carry into bit 0). With M=3 it rotates right (N+1 steps).
- R8: Mode 1, op[7:6]=3, shifts until bit N has reached the carry. M=4 is a left shift with 0 fill. M=5 is a right shift with 0 fill. M=6 is a right shift that fills with bit 7.
- R9: Mode 1, op[7:6]=3, M=7 rotates the byte left by N without the carry. Carry passes through.
- R10: Mode 2, op[7:6]=0, applies one Rule 30 step to every bit: new = left XOR (self OR right). The left neighbour of bit 7 is the carry in, and the right neighbour of bit 0 is operand bit N. Carry passes through.
- R11: Mode 2, op[7:6]=1, places a count in the result. M selects the count: 0 is ones including carry, 1 is zeros including carry, 2 is leading zeros, 3 is leading ones, 4 is trailing zeros and 5 is trailing ones. Leading and trailing counts run over the byte only, and a count over all 8 bits gives 8. M=6 or 7 gives 0. Carry passes through.
- R12: Mode 2, op[7:6]=2, converts the byte. M selects the conversion: 0 is Gray to binary, 1 is binary to Gray, 2 is bit reversal and 3 is packed BCD to binary (high digit times 10 plus low digit). M=4 gives the absolute value of a two's complement byte, with the carry out set to the input sign. Carry passes through for M=0 to 3.
- R13: Mode 2, op[7:6]=2, M=5 maps an ASCII hex character ('0'-'9', 'A'-'F', 'a'-'f') to its value with carry out 0. Any other character gives 0x00 with carry out 1. M=6 and M=7 map the low or high nibble to an uppercase ASCII hex character, with the carry passed through.
- R14: Mode 3 passes the byte and the carry through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_mode | input | 2 | Function family |
| in_op | input | 8 | Function code: group [7:6], N [5:3], M [2:0] |
| in_data | input | 8 | Operand byte |
| in_carry | input | 1 | Operand carry |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 8 | Result byte |
| out_carry | output | 1 | Result carry |

## Verification
Every result is due one register stage after its accepting edge. It can come later only while `out_ready` holds it back, and in that case it stays on the outputs unchanged. The driver pushes each expected result into a queue at the moment its operation is accepted. The monitor samples just after each falling edge and pops one entry for each output transfer, so order and timing are checked together however long the stalls last. During every stalled cycle the monitor also checks that `in_ready` is low and that the held result matches the one from the previous cycle.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  localparam int BYTE_W = 8;
  localparam int IDX_W  = $clog2(BYTE_W);
  localparam int CNT_W  = IDX_W + 1;
  localparam int RING_W = BYTE_W + 1;

  typedef enum logic [1:0] {
    MODE_PAIR  = 2'd0,
    MODE_CARRY = 2'd1,
    MODE_MISC  = 2'd2,
    MODE_PASS  = 2'd3
  } bo_mode_e;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              carry;
  } bo_res_t;

  // two-bit logic selected by the op group field
  function automatic logic bo_logic(input logic [1:0] grp, input logic a, input logic b);
    case (grp)
      2'd0:    return a & b;
      2'd1:    return a | b;
      default: return a ^ b;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] nib_to_hex(input logic [3:0] v);
    if (v < 4'd10) return 8'h30 + {4'b0, v};
    return 8'h37 + {4'b0, v};
  endfunction

endpackage

// File: rtl/bitop_logic.sv
module bitop_logic
  import bitop_pkg::*;
(
  input  bo_mode_e          mode,
  input  logic [BYTE_W-1:0] op,
  input  logic [BYTE_W-1:0] d,
  input  logic              c,
  output bo_res_t           res
);

  logic [1:0]       grp;
  logic [IDX_W-1:0] n;
  logic [IDX_W-1:0] m;
  logic             bn;
  logic             bm;
  logic             f;

  assign grp = op[7:6];
  assign n   = op[5:3];
  assign m   = op[2:0];
  assign bn  = d[n];
  assign bm  = d[m];

  always_comb begin
    res.data  = d;
    res.carry = c;
    f         = 1'b0;
    case (mode)
      MODE_PAIR: begin
        if (grp != 2'd3) begin
          f = bo_logic(grp, bn, bm);
          res.data[m] = f;
          res.carry   = f;
        end else begin
          res.data[n] = bm;
          res.data[m] = bn;
        end
      end
      MODE_CARRY: begin
        if (grp != 2'd3) begin
          f = bo_logic(grp, bn, c);
          res.data[m] = f;
          res.carry   = f;
        end else if (m == 3'd0) begin
          res.data[n] = c;
          res.carry   = bn;
        end else if (m == 3'd1) begin
          res.data[n] = c;
        end
      end
      MODE_MISC: begin
        res.carry = bn;
      end
      default: ;
    endcase
  end

  // a pair swap only moves bits, so the number of ones is kept (R4)
  always_comb begin
    if (!$isunknown({mode, op, d}) && mode == MODE_PAIR && grp == 2'd3)
      a_r4_swap_keeps_ones: assert ($countones(res.data) == $countones(d));
  end

endmodule

// File: rtl/bitop_shift.sv
module bitop_shift
  import bitop_pkg::*;
(
  input  logic [BYTE_W-1:0] op,
  input  logic [BYTE_W-1:0] d,
  input  logic              c,
  output bo_res_t           res
);

  logic [IDX_W-1:0]  n;
  logic [IDX_W-1:0]  m;
  logic [CNT_W-1:0]  kl;
  logic [CNT_W-1:0]  kr;
  logic [RING_W-1:0] ring;
  logic [RING_W-1:0] rol;
  logic [RING_W-1:0] ror;
  logic [RING_W-1:0] sll;
  logic [RING_W-1:0] srl;
  logic signed [RING_W-1:0] sra;
  logic [BYTE_W-1:0] cir;

  assign n    = op[5:3];
  assign m    = op[2:0];
  assign kl   = CNT_W'(BYTE_W) - {1'b0, n};
  assign kr   = {1'b0, n} + CNT_W'(1);
  assign ring = {c, d};

  assign rol = (ring << kl) | (ring >> (CNT_W'(RING_W) - kl));
  assign ror = (ring >> kr) | (ring << (CNT_W'(RING_W) - kr));
  assign sll = {1'b0, d} << kl;
  assign srl = {d, 1'b0} >> kr;
  assign sra = $signed({d, 1'b0}) >>> kr;
  assign cir = (d << n) | (d >> (CNT_W'(BYTE_W) - {1'b0, n}));

  always_comb begin
    res.data  = d;
    res.carry = c;
    case (m)
      3'd2: begin res.carry = rol[8]; res.data = rol[7:0]; end
      3'd3: begin res.carry = ror[8]; res.data = ror[7:0]; end
      3'd4: begin res.carry = sll[8]; res.data = sll[7:0]; end
      3'd5: begin res.carry = srl[0]; res.data = srl[8:1]; end
      3'd6: begin res.carry = sra[0]; res.data = sra[8:1]; end
      3'd7: begin res.data  = cir; end
      default: ;
    endcase
  end

  // rotations through carry keep the ring's ones count; the chosen bit lands in carry
  always_comb begin
    if (!$isunknown({op, d, c}) && (m == 3'd2 || m == 3'd3)) begin
      a_r7_ring_ones: assert ($countones({res.carry, res.data}) == $countones(ring));
      a_r7_bit_n_in_carry: assert (res.carry == d[n]);
    end
  end

endmodule

// File: rtl/bitop_misc.sv
module bitop_misc
  import bitop_pkg::*;
(
  input  logic [BYTE_W-1:0] op,
  input  logic [BYTE_W-1:0] d,
  input  logic              c,
  output bo_res_t           res
);

  logic [1:0]        grp;
  logic [IDX_W-1:0]  n;
  logic [IDX_W-1:0]  m;
  logic [BYTE_W-1:0] r30;
  logic [BYTE_W-1:0] g2b;
  logic [BYTE_W-1:0] rev;
  logic [CNT_W-1:0]  ones9;
  logic [CNT_W-1:0]  zeros9;
  logic [CNT_W-1:0]  lead0;
  logic [CNT_W-1:0]  lead1;
  logic [CNT_W-1:0]  trail0;
  logic [CNT_W-1:0]  trail1;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] hex_val;
  logic              hex_bad;

  assign grp = op[7:6];
  assign n   = op[5:3];
  assign m   = op[2:0];

  // cellular step and bit reversal, one cell per bit
  for (genvar i = 0; i < BYTE_W; i++) begin : g_cell
    logic lft;
    logic rgt;
    if (i == BYTE_W - 1) begin : g_top
      assign lft = c;
    end else begin : g_mid_l
      assign lft = d[i+1];
    end
    if (i == 0) begin : g_bot
      assign rgt = d[n];
    end else begin : g_mid_r
      assign rgt = d[i-1];
    end
    assign r30[i] = lft ^ (d[i] | rgt);
    assign rev[i] = d[BYTE_W-1-i];
    if (i == BYTE_W - 1) begin : g_gray_top
      assign g2b[i] = d[i];
    end else begin : g_gray
      assign g2b[i] = g2b[i+1] ^ d[i];
    end
  end

  always_comb begin
    ones9 = {{(CNT_W-1){1'b0}}, c};
    for (int i = 0; i < BYTE_W; i++) ones9 = ones9 + {{(CNT_W-1){1'b0}}, d[i]};
  end

  always_comb begin
    zeros9 = {{(CNT_W-1){1'b0}}, ~c};
    for (int i = 0; i < BYTE_W; i++) zeros9 = zeros9 + {{(CNT_W-1){1'b0}}, ~d[i]};
  end

  always_comb begin
    logic s0, s1, t0, t1;
    lead0 = '0; lead1 = '0; trail0 = '0; trail1 = '0;
    s0 = 1'b1; s1 = 1'b1; t0 = 1'b1; t1 = 1'b1;
    for (int i = 0; i < BYTE_W; i++) begin
      s0 = s0 & ~d[BYTE_W-1-i];
      s1 = s1 &  d[BYTE_W-1-i];
      t0 = t0 & ~d[i];
      t1 = t1 &  d[i];
      lead0  = lead0  + {{(CNT_W-1){1'b0}}, s0};
      lead1  = lead1  + {{(CNT_W-1){1'b0}}, s1};
      trail0 = trail0 + {{(CNT_W-1){1'b0}}, t0};
      trail1 = trail1 + {{(CNT_W-1){1'b0}}, t1};
    end
  end

  always_comb begin
    case (m)
      3'd0:    cnt = ones9;
      3'd1:    cnt = zeros9;
      3'd2:    cnt = lead0;
      3'd3:    cnt = lead1;
      3'd4:    cnt = trail0;
      3'd5:    cnt = trail1;
      default: cnt = '0;
    endcase
  end

  always_comb begin
    hex_bad = 1'b0;
    if (d >= 8'h30 && d <= 8'h39)      hex_val = d - 8'h30;
    else if (d >= 8'h41 && d <= 8'h46) hex_val = d - 8'h37;
    else if (d >= 8'h61 && d <= 8'h66) hex_val = d - 8'h57;
    else begin
      hex_val = '0;
      hex_bad = 1'b1;
    end
  end

  always_comb begin
    res.data  = d;
    res.carry = c;
    case (grp)
      2'd0: res.data = r30;
      2'd1: res.data = {{(BYTE_W-CNT_W){1'b0}}, cnt};
      2'd2: begin
        case (m)
          3'd0: res.data = g2b;
          3'd1: res.data = d ^ (d >> 1);
          3'd2: res.data = rev;
          3'd3: res.data = ({4'b0, d[7:4]} * 8'd10) + {4'b0, d[3:0]};
          3'd4: begin
            res.data  = d[BYTE_W-1] ? (~d + 8'd1) : d;
            res.carry = d[BYTE_W-1];
          end
          3'd5: begin
            res.data  = hex_val;
            res.carry = hex_bad;
          end
          3'd6: res.data = nib_to_hex(d[3:0]);
          default: res.data = nib_to_hex(d[7:4]);
        endcase
      end
      default: ;
    endcase
  end

  // ones and zeros over the nine cells always account for all of them (R11)
  always_comb begin
    if (!$isunknown({d, c}))
      a_r11_count_total: assert (({1'b0, ones9} + {1'b0, zeros9}) == 5'd9);
  end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [1:0]  in_mode,
  input  logic [7:0]  in_op,
  input  logic [7:0]  in_data,
  input  logic        in_carry,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_carry
);

  bo_mode_e mode;
  bo_res_t  res_logic;
  bo_res_t  res_shift;
  bo_res_t  res_misc;
  bo_res_t  res_sel;
  logic     use_shift;
  logic     use_misc;

  assign mode = bo_mode_e'(in_mode);

  bitop_logic u_logic (
    .mode (mode),
    .op   (in_op),
    .d    (in_data),
    .c    (in_carry),
    .res  (res_logic)
  );

  bitop_shift u_shift (
    .op   (in_op),
    .d    (in_data),
    .c    (in_carry),
    .res  (res_shift)
  );

  bitop_misc u_misc (
    .op   (in_op),
    .d    (in_data),
    .c    (in_carry),
    .res  (res_misc)
  );

  assign use_shift = (mode == MODE_CARRY) && (in_op[7:6] == 2'd3) && (in_op[2:1] != 2'd0);
  assign use_misc  = (mode == MODE_MISC)  && (in_op[7:6] != 2'd3);

  always_comb begin
    if (use_shift)     res_sel = res_shift;
    else if (use_misc) res_sel = res_misc;
    else               res_sel = res_logic;
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_carry <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data  <= res_sel.data;
        out_carry <= res_sel.carry;
      end
    end
  end

  a_r1_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_carry));

  a_r1_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r1_accept_to_valid: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r1_drain_empties: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

endmodule

// File: tb/sim_bitop_unit.sv
module sim_bitop_unit;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] in_mode = '0;
  logic [7:0] in_op = '0;
  logic [7:0] in_data = '0;
  logic       in_carry = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;
  logic       out_carry;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [8:0] q_exp[$];
  string      q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bitop_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_op(in_op), .in_data(in_data), .in_carry(in_carry),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_carry(out_carry)
  );

  // step-by-step reference taken from the requirements; returns {carry, byte}
  function automatic logic [8:0] model(input logic [1:0] md, input logic [7:0] op,
                                       input logic [7:0] d, input logic c);
    logic [1:0] g = op[7:6];
    int n = int'(op[5:3]);
    int m = int'(op[2:0]);
    logic [7:0] r = d;
    logic co = c;
    logic f;
    int k;
    case (md)
      2'd0: begin
        if (g == 2'd3) begin r[n] = d[m]; r[m] = d[n]; end
        else begin
          f = (g == 0) ? (d[n] & d[m]) : (g == 1) ? (d[n] | d[m]) : (d[n] ^ d[m]);
          r[m] = f; co = f;
        end
      end
      2'd1: begin
        if (g != 2'd3) begin
          f = (g == 0) ? (d[n] & c) : (g == 1) ? (d[n] | c) : (d[n] ^ c);
          r[m] = f; co = f;
        end else begin
          case (m)
            0: begin r[n] = c; co = d[n]; end
            1: r[n] = c;
            2: for (int s = 0; s < 8 - n; s++) begin f = r[7]; r = {r[6:0], co}; co = f; end
            3: for (int s = 0; s <= n; s++) begin f = r[0]; r = {co, r[7:1]}; co = f; end
            4: for (int s = 0; s < 8 - n; s++) begin co = r[7]; r = r << 1; end
            5: for (int s = 0; s <= n; s++) begin co = r[0]; r = r >> 1; end
            6: for (int s = 0; s <= n; s++) begin co = r[0]; r = {r[7], r[7:1]}; end
            default: for (int s = 0; s < n; s++) r = {r[6:0], r[7]};
          endcase
        end
      end
      2'd2: begin
        case (g)
          2'd0: for (int i = 0; i < 8; i++)
                  r[i] = ((i == 7) ? c : d[i+1]) ^ (d[i] | ((i == 0) ? d[n] : d[i-1]));
          2'd1: begin
            k = 0;
            case (m)
              0: begin k = c; for (int i = 0; i < 8; i++) k += d[i]; end
              1: begin k = !c; for (int i = 0; i < 8; i++) k += !d[i]; end
              2: while (k < 8 && d[7-k] == 1'b0) k++;
              3: while (k < 8 && d[7-k] == 1'b1) k++;
              4: while (k < 8 && d[k] == 1'b0) k++;
              5: while (k < 8 && d[k] == 1'b1) k++;
              default: k = 0;
            endcase
            r = 8'(k);
          end
          2'd2: begin
            case (m)
              0: begin r[7] = d[7]; for (int i = 6; i >= 0; i--) r[i] = r[i+1] ^ d[i]; end
              1: for (int i = 0; i < 8; i++) r[i] = d[i] ^ ((i == 7) ? 1'b0 : d[i+1]);
              2: for (int i = 0; i < 8; i++) r[i] = d[7-i];
              3: r = 8'(int'(d[7:4]) * 10 + int'(d[3:0]));
              4: begin r = d[7] ? 8'(0 - int'(d)) : d; co = d[7]; end
              5: begin
                if (d >= "0" && d <= "9") begin r = d - "0"; co = 0; end
                else if (d >= "A" && d <= "F") begin r = d - "A" + 8'd10; co = 0; end
                else if (d >= "a" && d <= "f") begin r = d - "a" + 8'd10; co = 0; end
                else begin r = 0; co = 1; end
              end
              default: begin
                k = (m == 6) ? int'(d[3:0]) : int'(d[7:4]);
                r = (k < 10) ? 8'("0" + k) : 8'("A" + k - 10);
              end
            endcase
          end
          default: co = d[n];
        endcase
      end
      default: ;
    endcase
    return {co, r};
  endfunction

  function automatic logic [7:0] opc(input int g, input int n, input int m);
    return {2'(g), 3'(n), 3'(m)};
  endfunction

  task automatic send(input logic [1:0] md, input logic [7:0] op, input logic [7:0] d,
                      input logic c, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_mode = md; in_op = op; in_data = d; in_carry = c;
    forever begin
      #1;
      if (in_ready) break;
      @(negedge clk);
    end
    q_exp.push_back(model(md, op, d, c));
    q_tag.push_back(tag);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  // monitor: drives out_ready, checks stalls and pops the scoreboard
  initial begin
    bit stall_prev = 0;
    logic [8:0] held = '0;
    logic [8:0] e;
    string t;
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = (cyc % 7 != 2) && (cyc % 11 != 5) && (cyc % 13 != 6);
      #1;
      if (rst_n) begin
        if (stall_prev) begin
          checks++;
          if (!out_valid || {out_carry, out_data} !== held) begin
            errors++;
            $display("FAIL R1 stall hold: got v=%b %h expected v=1 %h", out_valid,
                     {out_carry, out_data}, held);
          end
        end
        if (out_valid && !out_ready) begin
          checks++;
          if (in_ready !== 1'b0) begin
            errors++;
            $display("FAIL R1 in_ready during stall: got %b expected 0", in_ready);
          end
        end
        if (out_valid && out_ready) begin
          checks++;
          if (q_exp.size() == 0) begin
            errors++;
            $display("FAIL R1 unexpected output: got %h expected none", {out_carry, out_data});
          end else begin
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            if ({out_carry, out_data} !== e) begin
              errors++;
              $display("FAIL %s: got carry=%b data=%h expected carry=%b data=%h",
                       t, out_carry, out_data, e[8], e[7:0]);
            end
          end
        end
        stall_prev = out_valid && !out_ready;
        held = {out_carry, out_data};
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no finish expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R2 reset: got v=%b rdy=%b expected v=0 rdy=1", out_valid, in_ready);
    end
    @(negedge clk); rst_n = 1'b1;
    #2;
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R2 after reset: got v=%b expected 0", out_valid);
    end

    // R3 pair logic
    send(2'd0, opc(0, 5, 1), 8'hA5, 1'b0, "R3 and");
    send(2'd0, opc(0, 6, 1), 8'hA5, 1'b1, "R3 and zero");
    send(2'd0, opc(1, 6, 3), 8'h20, 1'b0, "R3 or");
    send(2'd0, opc(2, 7, 0), 8'h81, 1'b1, "R3 xor");
    // R4 pair swap
    send(2'd0, opc(3, 7, 0), 8'h80, 1'b1, "R4 swap");
    send(2'd0, opc(3, 2, 2), 8'h04, 1'b0, "R4 swap same");
    // R5 carry logic
    send(2'd1, opc(0, 3, 6), 8'h08, 1'b1, "R5 and");
    send(2'd1, opc(1, 0, 7), 8'h00, 1'b1, "R5 or");
    send(2'd1, opc(2, 4, 4), 8'h10, 1'b1, "R5 xor");
    // R6 swap and copies
    send(2'd1, opc(3, 4, 0), 8'h10, 1'b0, "R6 swap carry");
    send(2'd1, opc(3, 2, 1), 8'h00, 1'b1, "R6 copy carry in");
    send(2'd2, opc(3, 5, 0), 8'h20, 1'b0, "R6 copy to carry");
    // R7 rotates
    send(2'd1, opc(3, 0, 2), 8'h01, 1'b1, "R7 rotl n0");
    send(2'd1, opc(3, 7, 2), 8'h96, 1'b0, "R7 rotl n7");
    send(2'd1, opc(3, 3, 3), 8'h5A, 1'b1, "R7 rotr n3");
    send(2'd1, opc(3, 7, 3), 8'hC3, 1'b0, "R7 rotr n7");
    // R8 shifts
    send(2'd1, opc(3, 6, 4), 8'h4F, 1'b1, "R8 sll");
    send(2'd1, opc(3, 0, 4), 8'hFF, 1'b0, "R8 sll full");
    send(2'd1, opc(3, 2, 5), 8'hF4, 1'b0, "R8 srl");
    send(2'd1, opc(3, 3, 6), 8'h98, 1'b0, "R8 sra neg");
    send(2'd1, opc(3, 7, 6), 8'h80, 1'b0, "R8 sra full");
    // R9 circulate
    send(2'd1, opc(3, 3, 7), 8'h81, 1'b0, "R9 circulate");
    send(2'd1, opc(3, 0, 7), 8'h6C, 1'b1, "R9 circulate zero");
    // R10 rule 30
    send(2'd2, opc(0, 0, 0), 8'h10, 1'b0, "R10 rule30 single");
    send(2'd2, opc(0, 7, 0), 8'h80, 1'b1, "R10 rule30 bookends");
    // R11 counts
    send(2'd2, opc(1, 0, 0), 8'hF0, 1'b1, "R11 ones");
    send(2'd2, opc(1, 0, 1), 8'hF0, 1'b1, "R11 zeros");
    send(2'd2, opc(1, 0, 2), 8'h00, 1'b0, "R11 lead0 all");
    send(2'd2, opc(1, 0, 3), 8'hE5, 1'b0, "R11 lead1");
    send(2'd2, opc(1, 0, 4), 8'h40, 1'b1, "R11 trail0");
    send(2'd2, opc(1, 0, 5), 8'h17, 1'b0, "R11 trail1");
    send(2'd2, opc(1, 0, 6), 8'hFF, 1'b1, "R11 undefined");
    // R12 conversions
    send(2'd2, opc(2, 0, 0), 8'hC7, 1'b0, "R12 gray2bin");
    send(2'd2, opc(2, 0, 1), 8'hB5, 1'b1, "R12 bin2gray");
    send(2'd2, opc(2, 0, 2), 8'h1E, 1'b0, "R12 reverse");
    send(2'd2, opc(2, 0, 3), 8'h99, 1'b0, "R12 bcd");
    send(2'd2, opc(2, 0, 4), 8'hFB, 1'b0, "R12 abs neg");
    send(2'd2, opc(2, 0, 4), 8'h80, 1'b0, "R12 abs min");
    send(2'd2, opc(2, 0, 4), 8'h25, 1'b1, "R12 abs pos");
    // R13 ascii hex
    send(2'd2, opc(2, 0, 5), "7", 1'b1, "R13 digit");
    send(2'd2, opc(2, 0, 5), "e", 1'b1, "R13 lower");
    send(2'd2, opc(2, 0, 5), "F", 1'b1, "R13 upper");
    send(2'd2, opc(2, 0, 5), "G", 1'b0, "R13 invalid");
    send(2'd2, opc(2, 0, 6), 8'h3B, 1'b1, "R13 low nibble");
    send(2'd2, opc(2, 0, 7), 8'h3B, 1'b0, "R13 high nibble");
    // R14 pass
    send(2'd3, 8'hFF, 8'h5C, 1'b1, "R14 pass");
    send(2'd3, 8'h00, 8'hA3, 1'b0, "R14 pass b");

    while (q_exp.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule